// File: doc/BRIEF.md
# Retention-Aware Power Domain Sequencer

This block sequences the control bits of one switchable power domain. A power-on request raises the two power switches, waits for the switch acknowledge, opens the domain clock and isolation, and releases reset. A power-off request walks the same bits back down. Woven into both directions are the controls of the domain's state-retention flip-flops. On the way down, their contents are saved. On the way up, they may be restored. Each change of a control bit takes its own clock cycle, so every step is visible on the control word.

A static domain-type input chooses the retention flavour. Type 0 has no retention. Type 1 is a generic peripheral. Type 2 is a PCIe PHY, which also needs microsecond settling waits around isolation. Type 3 is a storage controller, which uses its own retention clock gate and always restores. For types 1 and 2, the restore is performed only if the save flag is 1. That flag lives in the control word. While the sequencer is idle, another agent can rewrite it through a small write port.

A cycle prescaler, set by the number of clocks per microsecond, times the waits. A busy level and a one-cycle done pulse frame each sequence.

Top module: `pd_retention_seq`

## Requirements
- R1: After synchronous reset, ctl_word has isolation (bit 1), clock disable (bit 4) and not-restore (bit 25) set, and every other bit clear. busy and done are 0.
- R2: The control word layout is reset_b bit 0, isolation bit 1, main switch bit 2, second switch bit 3, clock disable bit 4, retention save bit 24, not-restore bit 25, retention clock disable bit 26, save flag bit 27, storage retention clock disable bit 28. Types are 0 none, 1 generic, 2 PCIe PHY, 3 storage.
- R3: Power-on runs these steps, one clock each: set bit 2, set bit 3, wait until sw_ack is high, clear bit 4, clear bit 1, set bit 0. While sw_ack is low, nothing after bit 3 changes.
- R4: For type 2 only, power-on sets bit 26 just before clearing bit 4. It then holds for ON_WAIT_US×CLK_PER_US cycles after bit 1 clears, so that reset releases ON_WAIT_US×CLK_PER_US+1 cycles after isolation clears. For the other types, that gap is 1 cycle.
- R5: Once reset is released, types 1 and 2 restore only when bit 27 reads 1. Type 3 always restores, and type 0 never does. Without a restore, the sequence ends at reset release and bit 26 keeps its value.
- R6: The type 1 restore is: clear bit 27, set bit 26, clear bit 25, set bit 25, clear bit 26.
- R7: The type 2 restore is the type 1 order without the step that sets bit 26.
- R8: The type 3 restore is: set bit 28, clear bit 25, set bit 25, clear bit 28. Bit 27 is left untouched.
- R9: For types 1 and 2, power-off first sets bit 26, sets bit 24, clears bit 24, clears bit 26, then sets bit 27.
- R10: For type 3, the power-off save uses bit 28 in place of bit 26 and leaves bit 27 unchanged.
- R11: The power-off tail is: set bit 1, then wait OFF_WAIT_US×CLK_PER_US cycles (type 2 only), set bit 4, clear bit 0, clear bit 3, clear bit 2.
- R12: Type 0 changes no retention bit in either direction.
- R13: busy rises the cycle after a request is taken and falls in the same cycle as the last control change, with done high for exactly that one cycle. Requests made while busy are ignored. If both requests arrive together, power-on wins.
- R14: While idle, flag_wr_en loads flag_wr_val into bit 27 in the next cycle. While busy, the write port has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dom_type | input | 2 | Static retention type (0 none, 1 generic, 2 PCIe PHY, 3 storage) |
| pwr_on_req | input | 1 | Start a power-on sequence (taken when idle) |
| pwr_off_req | input | 1 | Start a power-off sequence (taken when idle) |
| sw_ack | input | 1 | Power switch acknowledge |
| flag_wr_en | input | 1 | Write strobe for the save flag |
| flag_wr_val | input | 1 | Value written into the save flag |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse at sequence end |
| ctl_word | output | 32 | Registered domain control word |

## Verification
The bench sweeps all four types against both save-flag values, in both directions. It compares the whole control word in every cycle with a trace that it builds from the step lists, so the checks expose the following faults:
- a restore that ignores the flag, or that runs for type 0;
- storage retention that clears the flag;
- a PHY restore that sets the clock gate twice;
- a reset release one cycle early or late relative to the microsecond wait.

In every sequence, the bench drives the opposite request and an opposite flag write into the middle of it. A design that honoured either one would show a wrong word or a restarted trace. A separate run holds the switch acknowledge low, to catch a sequencer that opens isolation before the switch is confirmed.

// File: rtl/pd_seq_pkg.sv
package pd_seq_pkg;

  localparam int CTL_W   = 32;
  // domain control bit positions
  localparam int B_RSTN  = 0;
  localparam int B_ISO   = 1;
  localparam int B_PWR   = 2;
  localparam int B_PWR2  = 3;
  localparam int B_CKOFF = 4;
  // retention control bit positions
  localparam int B_SAVE  = 24;
  localparam int B_NRES  = 25;
  localparam int B_RCLK  = 26;
  localparam int B_FLAG  = 27;
  localparam int B_SCLK  = 28;

  typedef enum logic [1:0] {
    DT_NONE    = 2'd0,
    DT_GENERIC = 2'd1,
    DT_PHY     = 2'd2,
    DT_STORAGE = 2'd3
  } dom_type_e;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_ON_PWR, ST_ON_PWR2, ST_ON_ACK, ST_ON_RCLK, ST_ON_CLK, ST_ON_ISO,
    ST_ON_WAIT, ST_ON_RST,
    ST_R_FLAG, ST_R_CKSET, ST_R_NRLO, ST_R_NRHI, ST_R_CKCLR,
    ST_S_CKSET, ST_S_SAVEHI, ST_S_SAVELO, ST_S_CKCLR, ST_S_FLAG,
    ST_OFF_ISO, ST_OFF_WAIT, ST_OFF_CLK, ST_OFF_RST, ST_OFF_PWR2, ST_OFF_PWR
  } step_e;

  function automatic logic [CTL_W-1:0] reset_word();
    logic [CTL_W-1:0] w;
    w = '0;
    w[B_ISO]   = 1'b1;
    w[B_CKOFF] = 1'b1;
    w[B_NRES]  = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/pd_us_timer.sv
module pd_us_timer #(
  parameter int CLK_PER_US = 125,
  parameter int US_W       = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [US_W-1:0] num_us,
  output logic            expire
);
  localparam int CYC_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CLK_PER_US - 1);

  logic [CYC_W-1:0] cyc_q;
  logic [US_W-1:0]  us_q;
  logic             cyc_wrap;

  assign cyc_wrap = (cyc_q == CYC_LAST);
  assign expire   = run && cyc_wrap && (us_q == num_us - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cyc_q <= '0;
      us_q  <= '0;
    end else if (cyc_wrap) begin
      cyc_q <= '0;
      us_q  <= us_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  // R4: the microsecond count never passes the requested length
  p_us_bound_r4: assert property (@(posedge clk) disable iff (rst)
    run |-> (us_q < num_us));

endmodule

// File: rtl/pd_seq_fsm.sv
module pd_seq_fsm
  import pd_seq_pkg::*;
#(
  parameter int ON_WAIT_US  = 5,
  parameter int OFF_WAIT_US = 1,
  parameter int US_W        = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  dom_type_e       dtype,
  input  logic            on_req,
  input  logic            off_req,
  input  logic            sw_ack,
  input  logic            save_flag,
  input  logic            tmr_expire,
  output step_e           step,
  output logic            tmr_run,
  output logic [US_W-1:0] tmr_us,
  output logic            busy,
  output logic            done
);
  step_e st_q, nxt;
  logic  is_phy, is_stor, do_restore;

  assign is_phy     = (dtype == DT_PHY);
  assign is_stor    = (dtype == DT_STORAGE);
  assign do_restore = is_stor || ((dtype == DT_GENERIC || is_phy) && save_flag);
  assign step       = st_q;
  assign tmr_run    = (st_q == ST_ON_WAIT) || (st_q == ST_OFF_WAIT);
  assign tmr_us     = (st_q == ST_ON_WAIT) ? US_W'(ON_WAIT_US) : US_W'(OFF_WAIT_US);

  always_comb begin
    nxt = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (on_req)       nxt = ST_ON_PWR;
        else if (off_req) nxt = (dtype == DT_NONE) ? ST_OFF_ISO : ST_S_CKSET;
      end
      ST_ON_PWR:   nxt = ST_ON_PWR2;
      ST_ON_PWR2:  nxt = ST_ON_ACK;
      ST_ON_ACK:   if (sw_ack) nxt = is_phy ? ST_ON_RCLK : ST_ON_CLK;
      ST_ON_RCLK:  nxt = ST_ON_CLK;
      ST_ON_CLK:   nxt = ST_ON_ISO;
      ST_ON_ISO:   nxt = is_phy ? ST_ON_WAIT : ST_ON_RST;
      ST_ON_WAIT:  if (tmr_expire) nxt = ST_ON_RST;
      ST_ON_RST: begin
        if (!do_restore) nxt = ST_IDLE;
        else             nxt = is_stor ? ST_R_CKSET : ST_R_FLAG;
      end
      ST_R_FLAG:   nxt = is_phy ? ST_R_NRLO : ST_R_CKSET;
      ST_R_CKSET:  nxt = ST_R_NRLO;
      ST_R_NRLO:   nxt = ST_R_NRHI;
      ST_R_NRHI:   nxt = ST_R_CKCLR;
      ST_R_CKCLR:  nxt = ST_IDLE;
      ST_S_CKSET:  nxt = ST_S_SAVEHI;
      ST_S_SAVEHI: nxt = ST_S_SAVELO;
      ST_S_SAVELO: nxt = ST_S_CKCLR;
      ST_S_CKCLR:  nxt = is_stor ? ST_OFF_ISO : ST_S_FLAG;
      ST_S_FLAG:   nxt = ST_OFF_ISO;
      ST_OFF_ISO:  nxt = is_phy ? ST_OFF_WAIT : ST_OFF_CLK;
      ST_OFF_WAIT: if (tmr_expire) nxt = ST_OFF_CLK;
      ST_OFF_CLK:  nxt = ST_OFF_RST;
      ST_OFF_RST:  nxt = ST_OFF_PWR2;
      ST_OFF_PWR2: nxt = ST_OFF_PWR;
      ST_OFF_PWR:  nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      st_q <= nxt;
      busy <= (nxt != ST_IDLE);
      done <= (st_q != ST_IDLE) && (nxt == ST_IDLE);
    end
  end

  p_done_single_r13: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r13: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_busy_end_r13: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_ack_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ON_ACK && !sw_ack) |=> (st_q == ST_ON_ACK));
  p_wait_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ON_WAIT && !tmr_expire) |=> (st_q == ST_ON_WAIT));

endmodule

// File: rtl/pd_ctl_reg.sv
module pd_ctl_reg
  import pd_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  step_e            step,
  input  dom_type_e        dtype,
  input  logic             flag_wr_en,
  input  logic             flag_wr_val,
  output logic [CTL_W-1:0] ctl_word
);
  logic [CTL_W-1:0] w_q, w_d;
  int               ck_bit;

  assign ck_bit   = (dtype == DT_STORAGE) ? B_SCLK : B_RCLK;
  assign ctl_word = w_q;

  always_comb begin
    w_d = w_q;
    case (step)
      ST_IDLE:     if (flag_wr_en) w_d[B_FLAG] = flag_wr_val;
      ST_ON_PWR:   w_d[B_PWR]   = 1'b1;
      ST_ON_PWR2:  w_d[B_PWR2]  = 1'b1;
      ST_ON_RCLK:  w_d[B_RCLK]  = 1'b1;
      ST_ON_CLK:   w_d[B_CKOFF] = 1'b0;
      ST_ON_ISO:   w_d[B_ISO]   = 1'b0;
      ST_ON_RST:   w_d[B_RSTN]  = 1'b1;
      ST_R_FLAG:   w_d[B_FLAG]  = 1'b0;
      ST_R_CKSET:  w_d[ck_bit]  = 1'b1;
      ST_R_NRLO:   w_d[B_NRES]  = 1'b0;
      ST_R_NRHI:   w_d[B_NRES]  = 1'b1;
      ST_R_CKCLR:  w_d[ck_bit]  = 1'b0;
      ST_S_CKSET:  w_d[ck_bit]  = 1'b1;
      ST_S_SAVEHI: w_d[B_SAVE]  = 1'b1;
      ST_S_SAVELO: w_d[B_SAVE]  = 1'b0;
      ST_S_CKCLR:  w_d[ck_bit]  = 1'b0;
      ST_S_FLAG:   w_d[B_FLAG]  = 1'b1;
      ST_OFF_ISO:  w_d[B_ISO]   = 1'b1;
      ST_OFF_CLK:  w_d[B_CKOFF] = 1'b1;
      ST_OFF_RST:  w_d[B_RSTN]  = 1'b0;
      ST_OFF_PWR2: w_d[B_PWR2]  = 1'b0;
      ST_OFF_PWR:  w_d[B_PWR]   = 1'b0;
      default:     w_d = w_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) w_q <= reset_word();
    else     w_q <= w_d;
  end

  p_rst_open_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(w_q[B_RSTN]) |-> (!w_q[B_ISO] && !w_q[B_CKOFF]));
  p_restore_in_reset_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(w_q[B_NRES]) |-> w_q[B_RSTN]);
  p_save_gated_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(w_q[B_SAVE]) |-> ((w_q[B_RCLK] || w_q[B_SCLK]) && !w_q[B_ISO]));
  p_none_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (dtype == DT_NONE) |-> (!w_q[B_SAVE] && w_q[B_NRES] && !w_q[B_SCLK]));
  p_flag_hold_r14: assert property (@(posedge clk) disable iff (rst)
    (step == ST_IDLE && !flag_wr_en) |=> $stable(w_q[B_FLAG]));

endmodule

// File: rtl/pd_retention_seq.sv
module pd_retention_seq
  import pd_seq_pkg::*;
#(
  parameter int CLK_PER_US  = 125,
  parameter int ON_WAIT_US  = 5,
  parameter int OFF_WAIT_US = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  dom_type,
  input  logic        pwr_on_req,
  input  logic        pwr_off_req,
  input  logic        sw_ack,
  input  logic        flag_wr_en,
  input  logic        flag_wr_val,
  output logic        busy,
  output logic        done,
  output logic [31:0] ctl_word
);
  localparam int MAX_US = (ON_WAIT_US > OFF_WAIT_US) ? ON_WAIT_US : OFF_WAIT_US;
  localparam int US_W   = $clog2(MAX_US + 1);

  dom_type_e         dtype;
  step_e             step;
  logic              tmr_run, tmr_expire;
  logic [US_W-1:0]   tmr_us;
  logic [CTL_W-1:0]  word;

  assign dtype    = dom_type_e'(dom_type);
  assign ctl_word = word;

  pd_us_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) u_timer (
    .clk(clk), .rst(rst), .run(tmr_run), .num_us(tmr_us), .expire(tmr_expire)
  );

  pd_seq_fsm #(.ON_WAIT_US(ON_WAIT_US), .OFF_WAIT_US(OFF_WAIT_US), .US_W(US_W)) u_fsm (
    .clk(clk), .rst(rst), .dtype(dtype), .on_req(pwr_on_req), .off_req(pwr_off_req),
    .sw_ack(sw_ack), .save_flag(word[B_FLAG]), .tmr_expire(tmr_expire),
    .step(step), .tmr_run(tmr_run), .tmr_us(tmr_us), .busy(busy), .done(done)
  );

  pd_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .step(step), .dtype(dtype),
    .flag_wr_en(flag_wr_en), .flag_wr_val(flag_wr_val), .ctl_word(word)
  );

endmodule

// File: tb/pd_retention_seq_bench.sv
module pd_retention_seq_bench;
  localparam int CPU = 3;
  localparam int ONW = 5;
  localparam int OFW = 1;
  localparam int RSTN = 0, ISO = 1, PWR = 2, PWR2 = 3, CKOFF = 4;
  localparam int SAVE = 24, NRES = 25, RCLK = 26, FLAG = 27, SCLK = 28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] dom_type = 2'd0;
  logic pwr_on_req = 1'b0, pwr_off_req = 1'b0, sw_ack = 1'b1;
  logic flag_wr_en = 1'b0, flag_wr_val = 1'b0;
  logic busy, done;
  logic [31:0] ctl_word;

  int checks = 0;
  int errors = 0;

  logic [31:0] mw;
  logic [31:0] exp_w [0:255];
  int s_cur;

  always #4 clk = ~clk;

  pd_retention_seq #(.CLK_PER_US(CPU), .ON_WAIT_US(ONW), .OFF_WAIT_US(OFW)) u_pd_retention_seq (
    .clk(clk), .rst(rst), .dom_type(dom_type), .pwr_on_req(pwr_on_req),
    .pwr_off_req(pwr_off_req), .sw_ack(sw_ack), .flag_wr_en(flag_wr_en),
    .flag_wr_val(flag_wr_val), .busy(busy), .done(done), .ctl_word(ctl_word)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exv, $time);
    end
  endtask

  task automatic op(input int b, input logic v, input int cyc);
    for (int t = s_cur; t < s_cur + cyc; t++) exp_w[t] = mw;
    s_cur += cyc;
    if (b >= 0) mw[b] = v;
  endtask

  task automatic build_on(input int ty);
    logic rest;
    op(PWR, 1'b1, 1); op(PWR2, 1'b1, 1); op(-1, 1'b0, 1);
    if (ty == 2) op(RCLK, 1'b1, 1);
    op(CKOFF, 1'b0, 1); op(ISO, 1'b0, 1);
    if (ty == 2) op(-1, 1'b0, ONW * CPU);
    op(RSTN, 1'b1, 1);
    rest = (ty == 3) || ((ty == 1 || ty == 2) && mw[FLAG]);
    if (rest) begin
      if (ty != 3) op(FLAG, 1'b0, 1);
      if (ty == 1) op(RCLK, 1'b1, 1);
      if (ty == 3) op(SCLK, 1'b1, 1);
      op(NRES, 1'b0, 1); op(NRES, 1'b1, 1);
      op((ty == 3) ? SCLK : RCLK, 1'b0, 1);
    end
  endtask

  task automatic build_off(input int ty);
    int ck;
    ck = (ty == 3) ? SCLK : RCLK;
    if (ty != 0) begin
      op(ck, 1'b1, 1); op(SAVE, 1'b1, 1); op(SAVE, 1'b0, 1); op(ck, 1'b0, 1);
      if (ty != 3) op(FLAG, 1'b1, 1);
    end
    op(ISO, 1'b1, 1);
    if (ty == 2) op(-1, 1'b0, OFW * CPU);
    op(CKOFF, 1'b1, 1); op(RSTN, 1'b0, 1); op(PWR2, 1'b0, 1); op(PWR, 1'b0, 1);
  endtask

  task automatic write_flag(input logic v);
    @(negedge clk); flag_wr_en = 1'b1; flag_wr_val = v;
    @(negedge clk); flag_wr_en = 1'b0;
    mw[FLAG] = v;
    chk(ctl_word === mw, "R14 idle flag write", ctl_word, mw);
  endtask

  // one whole sequence, compared against the model in every cycle (R2 R13)
  task automatic run_seq(input logic on, input int ty, input string tag);
    int total;
    s_cur = 0;
    if (on) build_on(ty); else build_off(ty);
    total = s_cur;
    for (int t = total; t < total + 4; t++) exp_w[t] = mw;
    @(negedge clk); pwr_on_req = on; pwr_off_req = !on;
    @(negedge clk); pwr_on_req = 1'b0; pwr_off_req = 1'b0;
    for (int s = 0; s < total + 4; s++) begin
      if (s == 2) begin
        pwr_on_req = !on; pwr_off_req = on;
        flag_wr_en = 1'b1; flag_wr_val = !ctl_word[FLAG];
      end
      if (s == 3) begin
        pwr_on_req = 1'b0; pwr_off_req = 1'b0; flag_wr_en = 1'b0;
      end
      chk(ctl_word === exp_w[s], {tag, " R2 word"}, ctl_word, exp_w[s]);
      chk(busy === (s < total), {tag, " R13 busy"}, {31'd0, busy}, {31'd0, s < total});
      chk(done === (s == total), {tag, " R13 done"}, {31'd0, done}, {31'd0, s == total});
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired actual busy expected idle");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] tmp;
    mw = 32'd0; mw[ISO] = 1'b1; mw[CKOFF] = 1'b1; mw[NRES] = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ctl_word === mw, "R1 reset word", ctl_word, mw);
    chk(!busy && !done, "R1 busy done low", {30'd0, busy, done}, 32'd0);

    for (int ty = 0; ty < 4; ty++) begin
      for (int f = 0; f < 2; f++) begin
        dom_type = 2'(ty);
        write_flag(f[0]);
        case (ty)
          0: run_seq(1'b1, ty, "R3 R12 on");
          1: run_seq(1'b1, ty, f ? "R3 R5 R6 on" : "R3 R5 on");
          2: run_seq(1'b1, ty, f ? "R4 R5 R7 on" : "R4 R5 on");
          default: run_seq(1'b1, ty, "R3 R5 R8 on");
        endcase
        case (ty)
          0: run_seq(1'b0, ty, "R11 R12 off");
          1: run_seq(1'b0, ty, "R9 R11 off");
          2: run_seq(1'b0, ty, "R9 R11 off");
          default: run_seq(1'b0, ty, "R10 R11 off");
        endcase
      end
    end

    // R3: nothing proceeds past the switches while the acknowledge is low
    dom_type = 2'd1;
    write_flag(1'b0);
    sw_ack = 1'b0;
    @(negedge clk); pwr_on_req = 1'b1;
    @(negedge clk); pwr_on_req = 1'b0;
    repeat (8) @(negedge clk);
    tmp = mw; tmp[PWR] = 1'b1; tmp[PWR2] = 1'b1;
    chk(ctl_word === tmp, "R3 hold for ack", ctl_word, tmp);
    chk(busy === 1'b1, "R3 busy during ack wait", {31'd0, busy}, 32'd1);
    sw_ack = 1'b1;
    s_cur = 0;
    build_on(1);
    for (int i = 0; i < 20 && busy; i++) @(negedge clk);
    chk(ctl_word === mw, "R3 final after ack", ctl_word, mw);
    run_seq(1'b0, 1, "R9 R11 off after ack");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule